// File: doc/BRIEF.md
# Command Ring Packet Decoder

This block walks a circular command ring held in memory, one 32-bit word at a time, and sorts each packet header it reads. Software programs the ring's base address and size through a small register-write port and then rings a doorbell by writing a new write offset. The block fetches headers over a simple request/response read port with one read in flight. It then advances its read offset until that offset meets the write offset.

Two packet kinds are consumed inside the block. A no-op carries a skip count. An indirect-buffer packet names a linear buffer elsewhere in memory; the block decodes that buffer to its end and then returns to the ring at the word after the indirect-buffer packet. Every other supported packet is handed to an execution port with its opcode, sub-opcode, full header and payload address. The block waits there until the executor reports done and says how many payload words it consumed. Malformed input or configuration stops the block with a sticky fault.

Top module: `cmd_ring_decoder`

## Requirements
- R1: After reset the block is idle (`busy`=0, `fault`=0), issues no memory read and presents no packet. The ring base is 0, the ring holds 256 bytes, the read and write offsets are 0 and the doorbell is disabled.
- R2: Register select 2 is the doorbell control; its bit 28 enables the doorbell. While that bit is clear, writes to select 3 (write offset) are ignored entirely.
- R3: A write-offset write (select 3, byte offset masked to the ring size) made while idle starts fetching. Made while busy it only moves the write offset, and it is never lost, even when it lands in the cycle the block decides to go idle.
- R4: Packets are decoded while the read offset differs from the write offset. When they match the block returns to idle (`busy`=0).
- R5: The opcode is header bits 7:0 and the sub-opcode bits 15:8. Opcodes 0x01 to 0x10, except 0x04, are presented on the execution port. `exe_addr` is the address of the word after the header, and the packet is held stable until `exe_done`. The read offset then advances by 4 × `exe_adv_dw` bytes beyond the header.
- R6: Opcode 0x00 is a no-op. Its header bits 29:16 give a count of extra dwords to skip; bits 31:30 are not part of the count.
- R7: Opcode 0x04 is an indirect buffer. The next ring word is the buffer's byte base address and the word after it is its length in dwords. The buffer's read offset starts at 0 and its end is length × 4 bytes. Decoding switches to the buffer and, once it drains, resumes on the ring after the three-word packet.
- R8: Register select 1 holds the ring size field in bits 6:1, and the ring byte size is 2^(field+2). A field below 6, above 62, or with field+2 above the `RING_LOG2_MAX` parameter (16 by default) raises the fault.
- R9: The ring read offset wraps modulo the ring byte size; ring addresses are base + offset.
- R10: An opcode above 0x10, or an indirect-buffer packet met inside an indirect buffer, raises the fault.
- R11: The fault is sticky until reset. While it is set no read is issued, nothing is presented for execution, `busy` is 0 and doorbells have no effect.
- R12: Memory reads are one-cycle request pulses with at most one outstanding; the next request waits for the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 doorbell control, 3 write offset |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | AW | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response word |
| exe_valid | output | 1 | Packet presented to the executor |
| exe_opcode | output | 8 | Opcode of the presented packet |
| exe_subop | output | 8 | Sub-opcode of the presented packet |
| exe_header | output | 32 | Full header word |
| exe_addr | output | AW | Address of the first payload word |
| exe_done | input | 1 | Executor finished the presented packet |
| exe_adv_dw | input | 16 | Payload dwords consumed, sampled with `exe_done` |
| busy | output | 1 | Ring walk in progress |
| fault | output | 1 | Sticky fault, block halted |

## Verification
Two events can land in one cycle: a doorbell write, and the pointer comparison that sends the walker back to idle after a packet completes. The bench provokes the overlap by queueing two packets, ringing the doorbell for only the first, and then moving the write offset over the second at each delay from zero to nine cycles after the first packet appears. For every delay it is judged by both packets being executed in order, with the second at the right payload address, and the block ending idle.

// File: rtl/crd_pkg.sv
// Shared constants and types for the command ring decoder.
// Assumes 32-bit command words and the opcode numbering listed here.
package crd_pkg;
    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_IB   = 8'h04;
    localparam logic [7:0] OPC_LAST = 8'h10;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_SIZE  = 2'd1;
    localparam logic [1:0] SEL_DBELL = 2'd2;
    localparam logic [1:0] SEL_WPTR  = 2'd3;

    localparam int DBELL_EN_BIT = 28;

    typedef enum logic [1:0] {PK_NOP, PK_IB, PK_EXEC, PK_BAD} pkt_kind_e;
    typedef enum logic [2:0] {ST_IDLE, ST_PICK, ST_REQ, ST_WAIT, ST_EXEC, ST_HALT} walk_st_e;
    typedef enum logic [1:0] {FK_HDR, FK_IBBASE, FK_IBSIZE} fetch_e;
endpackage

// File: rtl/crd_cfg_regs.sv
// Configuration registers: ring base, ring size, doorbell enable and write offset.
// Assumes AW <= 32, 8 <= PW <= 32. A size write is range-checked; a bad one is
// reported on size_fault and leaves the old size in place.
module crd_cfg_regs
    import crd_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [AW-1:0] ring_base,
    output logic [PW-1:0] ring_mask,
    output logic          db_en,
    output logic [PW-1:0] wptr_nxt,
    output logic          kick,
    output logic          size_fault
);
    localparam logic [6:0] RESET_LOG2 = 7'd8;
    localparam logic [6:0] PW_LIM     = 7'(PW);

    logic [AW-1:0] base_q;
    logic [6:0]    log2_q;
    logic          db_en_q;
    logic [PW-1:0] wptr_q;
    logic [5:0]    fld;
    logic [6:0]    fld_p2;
    logic          fld_ok;

    // Decode the requested size field and judge its range.
    always_comb begin
        fld    = cfg_wdata[6:1];
        fld_p2 = {1'b0, fld} + 7'd2;
        fld_ok = (fld >= 6'd6) && (fld <= 6'd62) && (fld_p2 <= PW_LIM);
    end

    // Byte mask of the ring: one bit per offset bit below the size exponent.
    for (genvar gi = 0; gi < PW; gi++) begin : g_mask
        assign ring_mask[gi] = (32'(gi) < 32'(log2_q));
    end

    assign kick       = cfg_we && (cfg_sel == SEL_WPTR) && db_en_q;
    assign size_fault = cfg_we && (cfg_sel == SEL_SIZE) && !fld_ok;
    assign wptr_nxt   = kick ? (cfg_wdata[PW-1:0] & ring_mask) : wptr_q;
    assign ring_base  = base_q;
    assign db_en      = db_en_q;

    // Register updates from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            log2_q  <= RESET_LOG2;
            db_en_q <= 1'b0;
            wptr_q  <= '0;
        end else begin
            wptr_q <= wptr_nxt;
            if (cfg_we && cfg_sel == SEL_BASE)  base_q  <= cfg_wdata[AW-1:0];
            if (cfg_we && cfg_sel == SEL_SIZE && fld_ok) log2_q <= fld_p2;
            if (cfg_we && cfg_sel == SEL_DBELL) db_en_q <= cfg_wdata[DBELL_EN_BIT];
        end
    end
endmodule

// File: rtl/crd_hdr_decode.sv
// Classifies a header word into no-op, indirect buffer, executable or bad.
// Pure combinational; an indirect buffer inside an indirect buffer is bad.
module crd_hdr_decode
    import crd_pkg::*;
(
    input  logic [31:0] hdr,
    input  logic        in_ib,
    output pkt_kind_e   kind,
    output logic [13:0] skip_dw
);
    logic [7:0] op;

    // Opcode classification.
    always_comb begin
        op = hdr[7:0];
        if (op == OPC_NOP)      kind = PK_NOP;
        else if (op == OPC_IB)  kind = in_ib ? PK_BAD : PK_IB;
        else if (op <= OPC_LAST) kind = PK_EXEC;
        else                    kind = PK_BAD;
    end

    assign skip_dw = hdr[29:16];
endmodule

// File: rtl/crd_walker.sv
// Ring / indirect-buffer walker: owns the read offsets, issues header and
// indirect-buffer payload reads, and hands executable packets out.
// Assumes one outstanding read and an executor that consumes payload itself.
// The ring size is assumed unchanged while the walker is busy.
module crd_walker
    import crd_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16,
    parameter int IW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic [PW-1:0] wptr_nxt,
    input  logic [AW-1:0] ring_base,
    input  logic [PW-1:0] ring_mask,
    input  logic          size_fault,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    input  pkt_kind_e     kind,
    input  logic [13:0]   skip_dw,
    input  logic          exe_done,
    input  logic [15:0]   exe_adv_dw,
    output logic          in_ib,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic          exe_valid,
    output logic [31:0]   exe_header,
    output logic [AW-1:0] exe_addr,
    output logic          busy,
    output logic          fault
);
    walk_st_e      st_q, st_d;
    fetch_e        fk_q, fk_d;
    logic [PW-1:0] rptr_q;
    logic [IW-1:0] ib_rptr_q, ib_wptr_q;
    logic [AW-1:0] ib_base_q;
    logic          in_ib_q;
    logic [31:0]   hdr_q;
    logic [AW-1:0] cur_addr;
    logic          adv_en, enter_ib, leave_ib, hdr_ld, ibbase_ld;
    logic [17:0]   adv_bytes;

    // Address of the next word on the active queue.
    assign cur_addr = in_ib_q ? (ib_base_q + AW'(ib_rptr_q))
                              : (ring_base + AW'(rptr_q));

    // Next state and pointer-advance decisions.
    always_comb begin
        st_d = st_q; fk_d = fk_q;
        adv_en = 1'b0; adv_bytes = '0;
        enter_ib = 1'b0; leave_ib = 1'b0; hdr_ld = 1'b0; ibbase_ld = 1'b0;
        case (st_q)
            ST_IDLE: if (kick) st_d = ST_PICK;
            ST_PICK: begin
                if (in_ib_q) begin
                    if (ib_rptr_q != ib_wptr_q) begin st_d = ST_REQ; fk_d = FK_HDR; end
                    else leave_ib = 1'b1;
                end else if (rptr_q != wptr_nxt) begin
                    st_d = ST_REQ; fk_d = FK_HDR;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_REQ: st_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
                case (fk_q)
                    FK_HDR: begin
                        hdr_ld = 1'b1;
                        case (kind)
                            PK_NOP: begin
                                adv_en = 1'b1;
                                adv_bytes = {(16'(skip_dw) + 16'd1), 2'b00};
                                st_d = ST_PICK;
                            end
                            PK_IB: begin
                                adv_en = 1'b1; adv_bytes = 18'd4;
                                fk_d = FK_IBBASE; st_d = ST_REQ;
                            end
                            PK_EXEC: begin
                                adv_en = 1'b1; adv_bytes = 18'd4;
                                st_d = ST_EXEC;
                            end
                            default: st_d = ST_HALT;
                        endcase
                    end
                    FK_IBBASE: begin
                        ibbase_ld = 1'b1; adv_en = 1'b1; adv_bytes = 18'd4;
                        fk_d = FK_IBSIZE; st_d = ST_REQ;
                    end
                    default: begin
                        enter_ib = 1'b1; adv_en = 1'b1; adv_bytes = 18'd4;
                        st_d = ST_PICK;
                    end
                endcase
            end
            ST_EXEC: if (exe_done) begin
                adv_en = 1'b1; adv_bytes = {exe_adv_dw, 2'b00};
                st_d = ST_PICK;
            end
            default: st_d = ST_HALT;
        endcase
        if (size_fault) st_d = ST_HALT;
    end

    // State, fetch kind and captured header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; fk_q <= FK_HDR; hdr_q <= '0; ib_base_q <= '0;
        end else begin
            st_q <= st_d; fk_q <= fk_d;
            if (hdr_ld)    hdr_q     <= mem_rsp_data;
            if (ibbase_ld) ib_base_q <= mem_rsp_data[AW-1:0];
        end
    end

    // Ring offset (wrapping) and buffer offsets (linear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0; ib_rptr_q <= '0; ib_wptr_q <= '0; in_ib_q <= 1'b0;
        end else begin
            if (adv_en && !in_ib_q) rptr_q <= (rptr_q + PW'(adv_bytes)) & ring_mask;
            if (enter_ib) begin
                ib_rptr_q <= '0;
                ib_wptr_q <= {mem_rsp_data[IW-3:0], 2'b00};
                in_ib_q   <= 1'b1;
            end else begin
                if (adv_en && in_ib_q) ib_rptr_q <= ib_rptr_q + IW'(adv_bytes);
                if (leave_ib) in_ib_q <= 1'b0;
            end
        end
    end

    assign in_ib         = in_ib_q;
    assign mem_req_valid = (st_q == ST_REQ);
    assign mem_req_addr  = cur_addr;
    assign exe_valid     = (st_q == ST_EXEC);
    assign exe_header    = hdr_q;
    assign exe_addr      = cur_addr;
    assign busy          = (st_q != ST_IDLE) && (st_q != ST_HALT);
    assign fault         = (st_q == ST_HALT);
endmodule

// File: rtl/cmd_ring_decoder.sv
// Top of the command ring packet decoder: registers, header classifier and
// walker. Executes nothing itself beyond no-op skipping and buffer chaining.
module cmd_ring_decoder
    import crd_pkg::*;
#(
    parameter int AW            = 32,
    parameter int RING_LOG2_MAX = 16,
    parameter int IB_OFF_W      = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          exe_valid,
    output logic [7:0]    exe_opcode,
    output logic [7:0]    exe_subop,
    output logic [31:0]   exe_header,
    output logic [AW-1:0] exe_addr,
    input  logic          exe_done,
    input  logic [15:0]   exe_adv_dw,
    output logic          busy,
    output logic          fault
);
    localparam int PW = RING_LOG2_MAX;

    logic [AW-1:0] ring_base;
    logic [PW-1:0] ring_mask, wptr_nxt;
    logic          db_en, kick, size_fault, in_ib;
    pkt_kind_e     kind;
    logic [13:0]   skip_dw;

    crd_cfg_regs #(.AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ring_base(ring_base), .ring_mask(ring_mask),
        .db_en(db_en), .wptr_nxt(wptr_nxt), .kick(kick), .size_fault(size_fault)
    );

    crd_hdr_decode u_dec (
        .hdr(mem_rsp_data), .in_ib(in_ib), .kind(kind), .skip_dw(skip_dw)
    );

    crd_walker #(.AW(AW), .PW(PW), .IW(IB_OFF_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .kick(kick), .wptr_nxt(wptr_nxt),
        .ring_base(ring_base), .ring_mask(ring_mask), .size_fault(size_fault),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .kind(kind), .skip_dw(skip_dw), .exe_done(exe_done),
        .exe_adv_dw(exe_adv_dw), .in_ib(in_ib), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .exe_valid(exe_valid),
        .exe_header(exe_header), .exe_addr(exe_addr), .busy(busy), .fault(fault)
    );

    assign exe_opcode = exe_header[7:0];
    assign exe_subop  = exe_header[15:8];
endmodule

// File: rtl/crd_checker.sv
// Protocol and state checks for cmd_ring_decoder, bound into every instance.
module crd_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic          db_en,
    input logic          busy,
    input logic          fault,
    input logic          mem_req_valid,
    input logic          exe_valid,
    input logic          exe_done,
    input logic [31:0]   exe_header,
    input logic [AW-1:0] exe_addr
);
    // R12: a request is a single-cycle pulse.
    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R5: no fetch while a packet is presented.
    assert_no_fetch_in_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> !mem_req_valid);

    // R5: a presented packet stays put until done.
    assert_exec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && !exe_done) |=> (exe_valid && $stable(exe_header) && $stable(exe_addr)));

    // R11: fault is sticky.
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R11: a faulted block is silent.
    assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && !mem_req_valid && !exe_valid));

    // R2: a write offset with the doorbell disabled does not start a walk.
    assert_dbell_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_sel == 2'd3 && !db_en) |=> !busy);
endmodule

bind cmd_ring_decoder crd_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .db_en(db_en), .busy(busy), .fault(fault), .mem_req_valid(mem_req_valid),
    .exe_valid(exe_valid), .exe_done(exe_done), .exe_header(exe_header),
    .exe_addr(exe_addr)
);

// File: tb/cmd_ring_decoder_tb_top.sv
// Directed bench: a word memory answers reads one cycle later, and an
// executor model accepts each packet after a few cycles, consuming the number
// of payload dwords given in header bits 23:16 (a bench convention).
module cmd_ring_decoder_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;
    logic          exe_valid;
    logic [7:0]    exe_opcode, exe_subop;
    logic [31:0]   exe_header;
    logic [AW-1:0] exe_addr;
    logic          exe_done;
    logic [15:0]   exe_adv_dw;
    logic          busy, fault;

    logic [31:0] mem [0:1023];
    logic [31:0] log_hdr  [0:15];
    logic [31:0] log_addr [0:15];
    int n_exec, n_req, n_b2b, ecnt;
    logic prev_req;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    cmd_ring_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .exe_valid(exe_valid),
        .exe_opcode(exe_opcode), .exe_subop(exe_subop), .exe_header(exe_header),
        .exe_addr(exe_addr), .exe_done(exe_done), .exe_adv_dw(exe_adv_dw),
        .busy(busy), .fault(fault)
    );

    // Memory model: answer each request on the following edge.
    always @(posedge clk) begin
        mem_rsp_valid <= rst_n && mem_req_valid;
        mem_rsp_data  <= mem[mem_req_addr[11:2]];
    end

    // Executor model and request monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            n_exec <= 0; n_req <= 0; n_b2b <= 0; ecnt <= 0; prev_req <= 1'b0;
            exe_done <= 1'b0; exe_adv_dw <= '0;
        end else begin
            exe_done <= 1'b0;
            prev_req <= mem_req_valid;
            if (mem_req_valid) n_req <= n_req + 1;
            if (mem_req_valid && (prev_req || mem_rsp_valid)) n_b2b <= n_b2b + 1;
            if (exe_valid && !exe_done) begin
                if (ecnt == 2) begin
                    exe_done <= 1'b1;
                    exe_adv_dw <= {8'h00, exe_header[23:16]};
                    log_hdr[n_exec[3:0]]  <= exe_header;
                    log_addr[n_exec[3:0]] <= exe_addr;
                    n_exec <= n_exec + 1;
                    ecnt <= 0;
                end else begin
                    ecnt <= ecnt + 1;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1; n_chk = n_chk + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        repeat (2) @(negedge clk);
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk(!busy, "R4 walk returns idle", 32'(busy), 32'd0);
    endtask

    task automatic setup(input logic [31:0] base);
        cfg_write(2'd0, base);
        cfg_write(2'd2, 32'h1000_0000);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(!busy && !fault, "R1 idle and no fault", {busy, fault}, 0);
        chk(!mem_req_valid && !exe_valid, "R1 no request or packet",
            {mem_req_valid, exe_valid}, 0);
    endtask

    task automatic t_exec();
        do_reset(); setup(32'h100);
        mem[64] = 32'h0002_0502; mem[65] = 32'hAAAA; mem[66] = 32'hBBBB;
        mem[67] = 32'h0000_010A;
        cfg_write(2'd3, 32'd16);
        wait_idle();
        chk(n_exec == 2, "R3 R4 two packets run", n_exec, 2);
        chk(log_hdr[0] == 32'h0002_0502, "R5 header passed", log_hdr[0], 32'h0002_0502);
        chk(log_addr[0] == 32'h104, "R5 payload address", log_addr[0], 32'h104);
        chk(log_hdr[1][7:0] == 8'h0A && log_hdr[1][15:8] == 8'h01,
            "R5 opcode and subop", log_hdr[1], 32'h0000_010A);
        chk(log_addr[1] == 32'h110, "R5 advance by payload", log_addr[1], 32'h110);
        chk(n_b2b == 0, "R12 one outstanding read", n_b2b, 0);
    endtask

    task automatic t_nop();
        do_reset(); setup(32'h100);
        mem[64] = 32'hC002_0000; mem[67] = 32'h0000_000D;
        cfg_write(2'd3, 32'd16);
        wait_idle();
        chk(n_exec == 1, "R6 one packet after skip", n_exec, 1);
        chk(log_addr[0] == 32'h110 && log_hdr[0][7:0] == 8'h0D,
            "R6 skip count from bits 29:16", log_addr[0], 32'h110);
    endtask

    task automatic t_ib();
        do_reset(); setup(32'h100);
        mem[64] = 32'h0000_0004; mem[65] = 32'h200; mem[66] = 32'd2;
        mem[67] = 32'h0000_0005;
        mem[128] = 32'h0000_0701; mem[129] = 32'h0000_0006;
        cfg_write(2'd3, 32'd16);
        wait_idle();
        chk(n_exec == 3, "R7 three packets", n_exec, 3);
        chk(log_hdr[0][7:0] == 8'h01 && log_addr[0] == 32'h204,
            "R7 buffer first packet", log_addr[0], 32'h204);
        chk(log_hdr[1][7:0] == 8'h06 && log_addr[1] == 32'h208,
            "R7 buffer second packet", log_addr[1], 32'h208);
        chk(log_hdr[2][7:0] == 8'h05 && log_addr[2] == 32'h110,
            "R7 resume on ring", log_addr[2], 32'h110);
    endtask

    task automatic t_wrap();
        do_reset(); setup(32'h100);
        mem[64] = 32'h003D_0000;
        cfg_write(2'd3, 32'd248);
        wait_idle();
        chk(n_exec == 0, "R9 skip to ring end", n_exec, 0);
        mem[64] = 32'h0000_0003; mem[126] = 32'h0001_0002;
        cfg_write(2'd3, 32'd4);
        wait_idle();
        chk(n_exec == 2, "R9 packets across wrap", n_exec, 2);
        chk(log_addr[0] == 32'h1FC, "R9 last ring word", log_addr[0], 32'h1FC);
        chk(log_hdr[1][7:0] == 8'h03 && log_addr[1] == 32'h104,
            "R9 offset wraps to base", log_addr[1], 32'h104);
    endtask

    task automatic t_size();
        do_reset(); setup(32'h100);
        cfg_write(2'd1, {25'd0, 6'd7, 1'b0});
        chk(!fault, "R8 field 7 accepted", 32'(fault), 0);
        mem[64] = 32'h003F_0000; mem[128] = 32'h0000_0002;
        cfg_write(2'd3, 32'd260);
        wait_idle();
        chk(n_exec == 1 && log_addr[0] == 32'h204, "R8 512-byte ring",
            log_addr[0], 32'h204);
        do_reset();
        cfg_write(2'd1, {25'd0, 6'd5, 1'b0});
        @(negedge clk);
        chk(fault, "R8 field below 6 faults", 32'(fault), 1);
        do_reset();
        cfg_write(2'd1, {25'd0, 6'd15, 1'b0});
        @(negedge clk);
        chk(fault, "R8 field above limit faults", 32'(fault), 1);
    endtask

    task automatic t_dbell_off();
        do_reset();
        cfg_write(2'd0, 32'h100);
        mem[64] = 32'h0000_0002;
        cfg_write(2'd3, 32'd4);
        repeat (10) @(negedge clk);
        chk(!busy && n_req == 0 && n_exec == 0, "R2 disabled doorbell ignored",
            n_req, 0);
        cfg_write(2'd2, 32'h1000_0000);
        cfg_write(2'd3, 32'd4);
        wait_idle();
        chk(n_exec == 1, "R2 enabled doorbell starts", n_exec, 1);
    endtask

    task automatic t_overlap();
        for (int k = 0; k < 10; k++) begin
            do_reset(); setup(32'h100);
            mem[64] = 32'h0000_0002; mem[65] = 32'h0000_0003;
            cfg_write(2'd3, 32'd4);
            while (!exe_valid) @(negedge clk);
            repeat (k) @(negedge clk);
            cfg_write(2'd3, 32'd8);
            wait_idle();
            chk(n_exec == 2 && log_hdr[1][7:0] == 8'h03 && log_addr[1] == 32'h108,
                $sformatf("R3 doorbell at delay %0d kept", k), n_exec, 2);
        end
    endtask

    task automatic t_bad();
        do_reset(); setup(32'h100);
        mem[64] = 32'h0000_0011; mem[65] = 32'h0000_0002;
        cfg_write(2'd3, 32'd4);
        repeat (10) @(negedge clk);
        chk(fault && !busy && n_exec == 0, "R10 opcode 0x11 faults", 32'(fault), 1);
        cfg_write(2'd3, 32'd8);
        repeat (10) @(negedge clk);
        chk(fault && n_exec == 0 && !busy, "R11 fault sticky, doorbell ignored",
            n_exec, 0);
        do_reset(); setup(32'h100);
        mem[64] = 32'h0000_0004; mem[65] = 32'h200; mem[66] = 32'd1;
        mem[128] = 32'h0000_0004;
        cfg_write(2'd3, 32'd12);
        repeat (20) @(negedge clk);
        chk(fault && n_exec == 0, "R10 nested buffer faults", 32'(fault), 1);
    endtask

    initial begin
        t_reset();
        t_exec();
        t_nop();
        t_ib();
        t_wrap();
        t_size();
        t_dbell_off();
        t_overlap();
        t_bad();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule